// File: doc/BRIEF.md
# Pending Request Tracker and Error Classifier

This block sits beside a memory-mapped slave bridge that turns bus reads into read requests and bus writes into write-with-response requests. Each issued request is entered in a small table keyed by its transaction ID, together with its kind, the expected read length and an age counter. Each decoded response is matched against that table. The block then sorts the outcome into one of four error classes: I/O error, unsolicited response, timeout or illegal decode. An ERROR status on a pending request counts as an I/O error. A response with no live entry, or one whose kind does not match its entry, is unsolicited. A pending request that is never answered times out. A response with a bad status code or a payload that does not fit its kind is an illegal decode.

Every class sets a sticky flag. The first error also loads a locked capture of the offending packet's fields. For every finished read, and for every read rejected by the address-window check, the block plays out a return burst toward the bus side. The burst carries a per-beat error indication, and it always runs to its full requested length, whether the read ended cleanly, failed or timed out.

Top module: `pend_resp_tracker`

## Requirements
- R1: After reset all error flags are 0, the capture is not valid (`capValid` = 0) and no return beat is driven.
- R2: A response whose kind matches a pending entry and whose status is ERROR (4'h7), and that passes the payload checks of R6, sets flag bit 0 (class code 0). The entry is freed, so a repeat of that response is unsolicited.
- R3: A response whose ID has no live entry, or whose read/write kind differs from the entry's kind, sets flag bit 1 (class code 1). A response that arrives after its request timed out falls in this class, and a kind-mismatched response leaves the entry pending.
- R4: A pending entry whose age reaches `timeoutLimit` cycles without a response is freed and sets flag bit 2 (class code 2). A `timeoutLimit` of 0 disables timeouts.
- R5: A matched response whose status is neither DONE (4'h0) nor ERROR (4'h7) sets flag bit 3 (class code 3).
- R6: A matched write response that has a payload (`rspPayloadPresent` = 1) or a data-bearing type (`rspDataType` = 1) sets flag bit 3.
- R7: A matched read response with DONE status sets flag bit 3 when its payload is absent, when its type is not data-bearing, or when `rspPayloadLen` differs from the requested length.
- R8: Every completed read returns exactly its requested number of beats, one per cycle and without a gap, with its ID on `rdBeatId` and `rdBeatLast` on the final beat. `rdBeatErr` is 0 for a clean DONE read and 1 on every beat after an ERROR, a timeout or an illegal decode. Bursts play out in completion order.
- R9: A read whose address lies outside the inclusive window [`winBase`, `winLimit`], or any read while `winEnable` = 0, is not tracked. It returns an error burst of its requested length and sets no flag, and a later response to its ID is unsolicited. Write requests are tracked whatever their address.
- R10: The first error loads the capture (class code, ID, kind, status, payload fields) and sets `capValid`. Later errors leave the capture unchanged but still set their flags. A `captureRelease` pulse clears `capValid`, and the next error loads the capture again. When a response error and a timeout occur in the same cycle, the response is captured.
- R11: Setting a bit of `errClear` clears that flag in the next cycle, unless the same cycle sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request issued this cycle |
| reqId | input | ID_W | Transaction ID of the request |
| reqIsRead | input | 1 | 1 = read request, 0 = write-with-response |
| reqLen | input | LEN_W | Expected read length in beats |
| reqAddr | input | ADDR_W | Request address for the window check |
| winEnable | input | 1 | Mapping window enabled |
| winBase | input | ADDR_W | Lowest address inside the window |
| winLimit | input | ADDR_W | Highest address inside the window |
| timeoutLimit | input | AGE_W | Response timeout in cycles, 0 = off |
| rspValid | input | 1 | Decoded response present this cycle |
| rspId | input | ID_W | Transaction ID of the response |
| rspIsRead | input | 1 | Response is for a read (1) or write (0) |
| rspDataType | input | 1 | Type code says a payload follows |
| rspPayloadPresent | input | 1 | Payload actually carried |
| rspPayloadLen | input | LEN_W | Payload length in beats |
| rspStatus | input | 4 | Status code, DONE = 0, ERROR = 7 |
| errClear | input | 4 | Per-flag clear strobes |
| captureRelease | input | 1 | Unlock the capture registers |
| errFlags | output | 4 | Sticky flags: 0 I/O error, 1 unsolicited, 2 timeout, 3 illegal decode |
| capValid | output | 1 | Capture loaded and locked |
| capClass | output | 2 | Captured error class code |
| capId | output | ID_W | Captured transaction ID |
| capIsRead | output | 1 | Captured kind |
| capStatus | output | 4 | Captured status |
| capDataType | output | 1 | Captured type-code payload bit |
| capPayloadPresent | output | 1 | Captured payload-present bit |
| capPayloadLen | output | LEN_W | Captured payload length |
| rdBeatValid | output | 1 | Return beat valid |
| rdBeatLast | output | 1 | Final beat of the burst |
| rdBeatErr | output | 1 | Beat belongs to a failed read |
| rdBeatId | output | ID_W | Transaction ID of the burst |

## Verification
Responses are driven in turn that are clean, ERROR-status, illegal-status, payload-mismatched in each of its three ways, kind-mismatched, repeated and late. Each must land in exactly one flag, so the flag word separates the class priority from the payload checks. Timeout stimulus compares an enabled limit against a zero limit, and window stimulus compares addresses at the top edge, above it, below it and with the window off. These separate the error-burst paths from flag-setting paths. A scoreboard of expected return beats checks burst length, ID, error bit and ordering across all of these. Capture checks around lock, release and reload show that the first error sticks while later flags still accumulate.

// File: rtl/prt_pkg.sv
package prt_pkg;

  localparam logic [3:0] ST_DONE  = 4'h0;
  localparam logic [3:0] ST_ERROR = 4'h7;

  typedef enum logic [1:0] {
    CLS_IOERR   = 2'd0,
    CLS_UNSOL   = 2'd1,
    CLS_TIMEOUT = 2'd2,
    CLS_ILLEGAL = 2'd3
  } errClass_e;

  // strobes from control to datapath (width-dependent fields travel beside it)
  typedef struct packed {
    logic [3:0] flagSet;
    logic       capLoad;
    errClass_e  capClass;
    logic       capIsRead;
    logic [3:0] capStatus;
    logic       capDataType;
    logic       capPresent;
    logic       enq;
    logic       enqErr;
  } strobes_t;

endpackage

// File: rtl/prt_ctrl.sv
module prt_ctrl
  import prt_pkg::*;
#(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = 3,
  parameter int LEN_W   = 4,
  parameter int AGE_W   = 16,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqIsRead,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              winEnable,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  input  logic [AGE_W-1:0]  timeoutLimit,
  input  logic              rspValid,
  input  logic [ID_W-1:0]   rspId,
  input  logic              rspIsRead,
  input  logic              rspDataType,
  input  logic              rspPayloadPresent,
  input  logic [LEN_W-1:0]  rspPayloadLen,
  input  logic [3:0]        rspStatus,
  output strobes_t          st,
  output logic [ID_W-1:0]   capIdOut,
  output logic [LEN_W-1:0]  capLenOut,
  output logic [ID_W-1:0]   enqId,
  output logic [LEN_W-1:0]  enqLen
);

  logic [NUM_IDS-1:0] entValid, entRead, entMiss, due;
  logic [LEN_W-1:0]   entLen [NUM_IDS];
  logic [AGE_W-1:0]   entAge [NUM_IDS];

  logic      hit, statusOk, wrBad, rdBad, respBad, respErr, respFree, respEnq;
  logic      winMiss, anyDue, scanGo, scanTimeout;
  logic [ID_W-1:0] pick;
  errClass_e respClass;

  assign winMiss  = !winEnable || (reqAddr < winBase) || (reqAddr > winLimit);
  assign hit      = entValid[rspId] && !entMiss[rspId] && (entRead[rspId] == rspIsRead);
  assign statusOk = (rspStatus == ST_DONE) || (rspStatus == ST_ERROR);
  assign wrBad    = !rspIsRead && (rspPayloadPresent || rspDataType);
  assign rdBad    = rspIsRead && (rspStatus == ST_DONE) &&
                    (!rspPayloadPresent || !rspDataType || (rspPayloadLen != entLen[rspId]));

  always_comb begin
    respClass = CLS_IOERR;
    respBad   = 1'b0;
    if (!hit) begin
      respClass = CLS_UNSOL;
      respBad   = 1'b1;
    end else if (!statusOk || wrBad || rdBad) begin
      respClass = CLS_ILLEGAL;
      respBad   = 1'b1;
    end else if (rspStatus == ST_ERROR) begin
      respClass = CLS_IOERR;
      respBad   = 1'b1;
    end
  end

  assign respErr  = rspValid && respBad;
  assign respFree = rspValid && hit;
  assign respEnq  = respFree && rspIsRead;

  // entries due for retirement: timed out or rejected by the window
  always_comb begin
    for (int i = 0; i < NUM_IDS; i++) begin
      due[i] = entValid[i] &&
               (entMiss[i] || ((timeoutLimit != '0) && (entAge[i] >= timeoutLimit))) &&
               !(respFree && (rspId == ID_W'(i)));
    end
  end

  always_comb begin
    anyDue = 1'b0;
    pick   = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (due[i]) begin
        anyDue = 1'b1;
        pick   = ID_W'(i);
      end
    end
  end

  // a response that queues a burst defers the scan by one cycle
  assign scanGo      = anyDue && !respEnq;
  assign scanTimeout = scanGo && !entMiss[pick];

  always_comb begin
    st          = '0;
    st.flagSet  = (respErr ? (4'b0001 << respClass) : 4'b0000) |
                  (scanTimeout ? 4'b0100 : 4'b0000);
    st.capLoad  = respErr || scanTimeout;
    capIdOut    = pick;
    capLenOut   = '0;
    if (respErr) begin
      st.capClass    = respClass;
      st.capIsRead   = rspIsRead;
      st.capStatus   = rspStatus;
      st.capDataType = rspDataType;
      st.capPresent  = rspPayloadPresent;
      capIdOut       = rspId;
      capLenOut      = rspPayloadLen;
    end else begin
      st.capClass    = CLS_TIMEOUT;
      st.capIsRead   = entRead[pick];
    end
    st.enq    = respEnq || (scanGo && entRead[pick]);
    st.enqErr = respEnq ? respBad : 1'b1;
    enqId     = respEnq ? rspId : pick;
    enqLen    = respEnq ? entLen[rspId] : entLen[pick];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entRead  <= '0;
      entMiss  <= '0;
      for (int i = 0; i < NUM_IDS; i++) begin
        entLen[i] <= '0;
        entAge[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_IDS; i++) begin
        if (reqValid && (reqId == ID_W'(i))) begin
          entValid[i] <= 1'b1;
          entRead[i]  <= reqIsRead;
          entMiss[i]  <= reqIsRead && winMiss;
          entLen[i]   <= reqLen;
          entAge[i]   <= '0;
        end else if ((respFree && (rspId == ID_W'(i))) || (scanGo && (pick == ID_W'(i)))) begin
          entValid[i] <= 1'b0;
        end else if (entValid[i] && (entAge[i] != '1)) begin
          entAge[i] <= entAge[i] + 1'b1;
        end
      end
    end
  end

  // R2: a matched response retires its entry
  p_free_on_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && hit && !(reqValid && (reqId == rspId))) |=> !entValid[$past(rspId)]);

  // R9: a window-rejected read is retired within two cycles when no response competes
  p_miss_retired_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsRead && winMiss && !rspValid) |=> ##1
      ($past(rspValid) || $past(reqValid) || !entMiss[$past(reqId, 2)] || !entValid[$past(reqId, 2)]));

endmodule

// File: rtl/prt_datapath.sv
module prt_datapath
  import prt_pkg::*;
#(
  parameter int ID_W       = 3,
  parameter int LEN_W      = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic [ID_W-1:0]  capIdIn,
  input  logic [LEN_W-1:0] capLenIn,
  input  logic [ID_W-1:0]  enqId,
  input  logic [LEN_W-1:0] enqLen,
  input  logic [3:0]       errClear,
  input  logic             captureRelease,
  output logic [3:0]       errFlags,
  output logic             capValid,
  output logic [1:0]       capClass,
  output logic [ID_W-1:0]  capId,
  output logic             capIsRead,
  output logic [3:0]       capStatus,
  output logic             capDataType,
  output logic             capPayloadPresent,
  output logic [LEN_W-1:0] capPayloadLen,
  output logic             rdBeatValid,
  output logic             rdBeatLast,
  output logic             rdBeatErr,
  output logic [ID_W-1:0]  rdBeatId
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [ID_W-1:0]  fId  [FIFO_DEPTH];
  logic [LEN_W-1:0] fLen [FIFO_DEPTH];
  logic             fErr [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [LEN_W-1:0] remain;
  logic             pop, doEnq, full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // flags and capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlags          <= '0;
      capValid          <= 1'b0;
      capClass          <= '0;
      capId             <= '0;
      capIsRead         <= 1'b0;
      capStatus         <= '0;
      capDataType       <= 1'b0;
      capPayloadPresent <= 1'b0;
      capPayloadLen     <= '0;
    end else begin
      errFlags <= (errFlags & ~errClear) | st.flagSet;
      if (st.capLoad && (!capValid || captureRelease)) begin
        capValid          <= 1'b1;
        capClass          <= st.capClass;
        capId             <= capIdIn;
        capIsRead         <= st.capIsRead;
        capStatus         <= st.capStatus;
        capDataType       <= st.capDataType;
        capPayloadPresent <= st.capPresent;
        capPayloadLen     <= capLenIn;
      end else if (captureRelease) begin
        capValid <= 1'b0;
      end
    end
  end

  // burst queue
  assign full  = (count == CNT_W'(FIFO_DEPTH));
  assign pop   = (remain <= LEN_W'(1)) && (count != '0);
  assign doEnq = st.enq && (!full || pop);

  always_ff @(posedge clk) begin
    if (doEnq) begin
      fId[wrPtr]  <= enqId;
      fLen[wrPtr] <= enqLen;
      fErr[wrPtr] <= st.enqErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      remain    <= '0;
      rdBeatId  <= '0;
      rdBeatErr <= 1'b0;
    end else begin
      if (doEnq) wrPtr <= bump(wrPtr);
      if (pop)   rdPtr <= bump(rdPtr);
      count <= count + CNT_W'(doEnq) - CNT_W'(pop);
      if (remain > LEN_W'(1)) begin
        remain <= remain - 1'b1;
      end else if (pop) begin
        remain    <= fLen[rdPtr];
        rdBeatId  <= fId[rdPtr];
        rdBeatErr <= fErr[rdPtr];
      end else begin
        remain <= '0;
      end
    end
  end

  assign rdBeatValid = (remain != '0);
  assign rdBeatLast  = (remain == LEN_W'(1));

  // R8: the burst queue never drops a completion
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(st.enq && full && !pop));

  // R8: a burst is never cut short and keeps its ID and error bit
  p_burst_whole_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdBeatValid && !rdBeatLast) |=> (rdBeatValid && $stable(rdBeatId) && $stable(rdBeatErr)));

  // R10: a locked capture holds its contents until released
  p_cap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && !captureRelease) |=>
      (capValid && $stable(capClass) && $stable(capId) && $stable(capStatus) && $stable(capIsRead)));

  // R11: a set flag stays set unless cleared
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errFlags & $past(errFlags & ~errClear)) == $past(errFlags & ~errClear)));

endmodule

// File: rtl/pend_resp_tracker.sv
module pend_resp_tracker
  import prt_pkg::*;
#(
  parameter int NUM_IDS    = 8,
  parameter int LEN_W      = 4,
  parameter int AGE_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 8,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqIsRead,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              winEnable,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  input  logic [AGE_W-1:0]  timeoutLimit,
  input  logic              rspValid,
  input  logic [ID_W-1:0]   rspId,
  input  logic              rspIsRead,
  input  logic              rspDataType,
  input  logic              rspPayloadPresent,
  input  logic [LEN_W-1:0]  rspPayloadLen,
  input  logic [3:0]        rspStatus,
  input  logic [3:0]        errClear,
  input  logic              captureRelease,
  output logic [3:0]        errFlags,
  output logic              capValid,
  output logic [1:0]        capClass,
  output logic [ID_W-1:0]   capId,
  output logic              capIsRead,
  output logic [3:0]        capStatus,
  output logic              capDataType,
  output logic              capPayloadPresent,
  output logic [LEN_W-1:0]  capPayloadLen,
  output logic              rdBeatValid,
  output logic              rdBeatLast,
  output logic              rdBeatErr,
  output logic [ID_W-1:0]   rdBeatId
);

  strobes_t         st;
  logic [ID_W-1:0]  capIdW, enqId;
  logic [LEN_W-1:0] capLenW, enqLen;

  prt_ctrl #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .LEN_W(LEN_W), .AGE_W(AGE_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqId(reqId), .reqIsRead(reqIsRead), .reqLen(reqLen),
    .reqAddr(reqAddr), .winEnable(winEnable), .winBase(winBase), .winLimit(winLimit),
    .timeoutLimit(timeoutLimit),
    .rspValid(rspValid), .rspId(rspId), .rspIsRead(rspIsRead), .rspDataType(rspDataType),
    .rspPayloadPresent(rspPayloadPresent), .rspPayloadLen(rspPayloadLen), .rspStatus(rspStatus),
    .st(st), .capIdOut(capIdW), .capLenOut(capLenW), .enqId(enqId), .enqLen(enqLen)
  );

  prt_datapath #(
    .ID_W(ID_W), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .capIdIn(capIdW), .capLenIn(capLenW), .enqId(enqId), .enqLen(enqLen),
    .errClear(errClear), .captureRelease(captureRelease),
    .errFlags(errFlags), .capValid(capValid), .capClass(capClass), .capId(capId),
    .capIsRead(capIsRead), .capStatus(capStatus), .capDataType(capDataType),
    .capPayloadPresent(capPayloadPresent), .capPayloadLen(capPayloadLen),
    .rdBeatValid(rdBeatValid), .rdBeatLast(rdBeatLast), .rdBeatErr(rdBeatErr),
    .rdBeatId(rdBeatId)
  );

endmodule

// File: tb/pend_resp_tracker_bench.sv
module pend_resp_tracker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqIsRead;
  logic [2:0]  reqId;
  logic [3:0]  reqLen;
  logic [31:0] reqAddr;
  logic        winEnable;
  logic [31:0] winBase, winLimit;
  logic [15:0] timeoutLimit;
  logic        rspValid, rspIsRead, rspDataType, rspPayloadPresent;
  logic [2:0]  rspId;
  logic [3:0]  rspPayloadLen, rspStatus;
  logic [3:0]  errClear;
  logic        captureRelease;
  logic [3:0]  errFlags;
  logic        capValid, capIsRead, capDataType, capPayloadPresent;
  logic [1:0]  capClass;
  logic [2:0]  capId;
  logic [3:0]  capStatus, capPayloadLen;
  logic        rdBeatValid, rdBeatLast, rdBeatErr;
  logic [2:0]  rdBeatId;

  pend_resp_tracker u_pend_resp_tracker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqId(reqId), .reqIsRead(reqIsRead), .reqLen(reqLen),
    .reqAddr(reqAddr), .winEnable(winEnable), .winBase(winBase), .winLimit(winLimit),
    .timeoutLimit(timeoutLimit),
    .rspValid(rspValid), .rspId(rspId), .rspIsRead(rspIsRead), .rspDataType(rspDataType),
    .rspPayloadPresent(rspPayloadPresent), .rspPayloadLen(rspPayloadLen), .rspStatus(rspStatus),
    .errClear(errClear), .captureRelease(captureRelease),
    .errFlags(errFlags), .capValid(capValid), .capClass(capClass), .capId(capId),
    .capIsRead(capIsRead), .capStatus(capStatus), .capDataType(capDataType),
    .capPayloadPresent(capPayloadPresent), .capPayloadLen(capPayloadLen),
    .rdBeatValid(rdBeatValid), .rdBeatLast(rdBeatLast), .rdBeatErr(rdBeatErr),
    .rdBeatId(rdBeatId)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct { int id; bit err; bit last; } beat_t;
  beat_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectBurst(input int id, input int len, input bit err);
    for (int i = 1; i <= len; i++) begin
      beat_t b;
      b.id = id; b.err = err; b.last = (i == len);
      expQ.push_back(b);
    end
  endtask

  task automatic issue(input int id, input bit isRd, input int len, input logic [31:0] addr);
    reqValid = 1'b1; reqId = id[2:0]; reqIsRead = isRd; reqLen = len[3:0]; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic respond(input int id, input bit isRd, input bit dt, input bit pres,
                         input int len, input int status);
    rspValid = 1'b1; rspId = id[2:0]; rspIsRead = isRd; rspDataType = dt;
    rspPayloadPresent = pres; rspPayloadLen = len[3:0]; rspStatus = status[3:0];
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic clearAll();
    errClear = 4'hF; captureRelease = 1'b1;
    @(negedge clk);
    errClear = 4'h0; captureRelease = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkFlags(input int exp, input string req);
    check(errFlags == exp[3:0], req, "errFlags", int'(errFlags), exp);
  endtask

  task automatic checkCap(input int cls, input int id, input bit rd, input string req);
    check(capValid == 1'b1, req, "capValid", int'(capValid), 1);
    check(capClass == cls[1:0], req, "capClass", int'(capClass), cls);
    check(capId == id[2:0], req, "capId", int'(capId), id);
    check(capIsRead == rd, req, "capIsRead", int'(capIsRead), int'(rd));
  endtask

  // monitor: compare each return beat with the scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b1 && rdBeatValid === 1'b1) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R8 unexpected beat: actual id %0d expected none", rdBeatId);
      end else begin
        beat_t e;
        e = expQ.pop_front();
        if (rdBeatId != e.id[2:0] || rdBeatErr != e.err || rdBeatLast != e.last) begin
          nFails++;
          $display("FAIL R8 beat: actual id %0d err %0d last %0d expected id %0d err %0d last %0d",
                   rdBeatId, rdBeatErr, rdBeatLast, e.id, e.err, e.last);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqId = '0; reqIsRead = 1'b0; reqLen = '0; reqAddr = '0;
    winEnable = 1'b1; winBase = 32'h1000; winLimit = 32'h1FFF; timeoutLimit = 16'd1000;
    rspValid = 1'b0; rspId = '0; rspIsRead = 1'b0; rspDataType = 1'b0;
    rspPayloadPresent = 1'b0; rspPayloadLen = '0; rspStatus = '0;
    errClear = '0; captureRelease = 1'b0;
    tick(4);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    checkFlags(0, "R1");
    check(capValid == 1'b0, "R1", "capValid", int'(capValid), 0);
    check(rdBeatValid == 1'b0, "R1", "rdBeatValid", int'(rdBeatValid), 0);

    // R8 clean read at the top window edge
    expectBurst(1, 4, 1'b0);
    issue(1, 1'b1, 4, 32'h1FFF);
    tick(3);
    respond(1, 1'b1, 1'b1, 1'b1, 4, 0);
    tick(12);
    checkFlags(0, "R8");

    // clean write response
    issue(2, 1'b0, 1, 32'h1000);
    respond(2, 1'b0, 1'b0, 1'b0, 0, 0);
    tick(4);
    checkFlags(0, "R6");

    // R2 ERROR on read, then R3 repeat while capture locked (R10)
    expectBurst(3, 2, 1'b1);
    issue(3, 1'b1, 2, 32'h1100);
    tick(2);
    respond(3, 1'b1, 1'b0, 1'b0, 0, 7);
    tick(10);
    checkFlags(1, "R2");
    checkCap(0, 3, 1'b1, "R10");
    check(capStatus == 4'h7, "R10", "capStatus", int'(capStatus), 7);
    respond(3, 1'b1, 1'b0, 1'b0, 0, 7);
    tick(4);
    checkFlags(3, "R3");
    checkCap(0, 3, 1'b1, "R10");

    // R11 clear and R10 release
    clearAll();
    checkFlags(0, "R11");
    check(capValid == 1'b0, "R10", "capValid after release", int'(capValid), 0);

    // R6 write with payload, capture reloads
    issue(4, 1'b0, 1, 32'h1000);
    respond(4, 1'b0, 1'b0, 1'b1, 1, 0);
    tick(4);
    checkFlags(8, "R6");
    checkCap(3, 4, 1'b0, "R10");
    clearAll();

    // R6 write with data-bearing type
    issue(5, 1'b0, 1, 32'h1000);
    respond(5, 1'b0, 1'b1, 1'b0, 0, 0);
    tick(4);
    checkFlags(8, "R6");
    clearAll();

    // R7 length mismatch
    expectBurst(6, 3, 1'b1);
    issue(6, 1'b1, 3, 32'h1000);
    respond(6, 1'b1, 1'b1, 1'b1, 2, 0);
    tick(10);
    checkFlags(8, "R7");
    clearAll();

    // R7 missing payload
    expectBurst(7, 1, 1'b1);
    issue(7, 1'b1, 1, 32'h1000);
    respond(7, 1'b1, 1'b1, 1'b0, 0, 0);
    tick(8);
    checkFlags(8, "R7");
    clearAll();

    // R7 non-data type code
    expectBurst(0, 1, 1'b1);
    issue(0, 1'b1, 1, 32'h1000);
    respond(0, 1'b1, 1'b0, 1'b1, 1, 0);
    tick(8);
    checkFlags(8, "R7");
    clearAll();

    // R5 illegal status code
    issue(1, 1'b0, 1, 32'h1000);
    respond(1, 1'b0, 1'b0, 1'b0, 0, 3);
    tick(4);
    checkFlags(8, "R5");
    check(capStatus == 4'h3, "R5", "capStatus", int'(capStatus), 3);
    clearAll();

    // R3 kind mismatch leaves the entry pending
    issue(2, 1'b1, 2, 32'h1000);
    respond(2, 1'b0, 1'b0, 1'b0, 0, 0);
    tick(4);
    checkFlags(2, "R3");
    checkCap(1, 2, 1'b0, "R3");
    clearAll();
    expectBurst(2, 2, 1'b0);
    respond(2, 1'b1, 1'b1, 1'b1, 2, 0);
    tick(10);
    checkFlags(0, "R3");

    // R4 timeout on a read, then a late response is unsolicited
    timeoutLimit = 16'd20;
    expectBurst(3, 2, 1'b1);
    issue(3, 1'b1, 2, 32'h1000);
    tick(30);
    checkFlags(4, "R4");
    checkCap(2, 3, 1'b1, "R4");
    respond(3, 1'b1, 1'b1, 1'b1, 2, 0);
    tick(4);
    checkFlags(6, "R3");
    clearAll();

    // R4 timeout on a write: flag only, no burst
    issue(5, 1'b0, 1, 32'h1000);
    tick(30);
    checkFlags(4, "R4");
    clearAll();

    // R4 zero limit disables timeouts
    timeoutLimit = 16'd0;
    expectBurst(4, 1, 1'b0);
    issue(4, 1'b1, 1, 32'h1000);
    tick(40);
    checkFlags(0, "R4");
    respond(4, 1'b1, 1'b1, 1'b1, 1, 0);
    tick(8);
    checkFlags(0, "R4");
    timeoutLimit = 16'd1000;

    // R9 above the window
    expectBurst(5, 3, 1'b1);
    issue(5, 1'b1, 3, 32'h2000);
    tick(8);
    checkFlags(0, "R9");
    respond(5, 1'b1, 1'b1, 1'b1, 3, 0);
    tick(4);
    checkFlags(2, "R9");
    clearAll();

    // R9 below the window
    expectBurst(6, 2, 1'b1);
    issue(6, 1'b1, 2, 32'h0FFF);
    tick(8);
    checkFlags(0, "R9");

    // R9 window disabled
    winEnable = 1'b0;
    expectBurst(7, 1, 1'b1);
    issue(7, 1'b1, 1, 32'h1000);
    tick(8);
    checkFlags(0, "R9");
    winEnable = 1'b1;

    // R9 write outside the window is still tracked
    issue(1, 1'b0, 1, 32'h5000);
    respond(1, 1'b0, 1'b0, 1'b0, 0, 0);
    tick(4);
    checkFlags(0, "R9");

    tick(10);
    check(expQ.size() == 0, "R8", "beats still expected", expQ.size(), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule